// File: doc/BRIEF.md
# SHA-256 Block Compression Engine

This block computes the SHA-256 hash of a message that arrives as 32-bit words, sixteen words (one 512-bit block) at a time. The caller pulses `start_i` to load the eight standard initial hash words and clear the word counter. It then presents message words on `wr_data_i` with `wr_valid_i`. A word is taken on any clock edge where the engine reports ready. The caller must pad the message to a whole number of blocks.

There is no input FIFO. Each accepted word goes straight into a sixteen-entry sliding message schedule, and the compression round for that word runs in the same cycle. After the sixteenth word, the engine drops ready for a fixed window of 57 cycles. In that window it runs the remaining 48 rounds and adds the working state into the running digest. The remaining cycles of the window are idle. Digest-valid drops when the first word of a block is taken and rises again at the end of the window. Successive blocks chain onto the running digest until the next start pulse.

Top module: `sha256_block_engine`

## Requirements
- R1: After reset, `ready_o` is 1, `digest_valid_o` is 1, and `digest_o` holds the initial hash value 6a09e667 bb67ae85 3c6ef372 a54ff53a 510e527f 9b05688c 1f83d9ab 5be0cd19, with H0 in bits 255:224.
- R2: In the cycle after a `start_i` pulse, `ready_o` and `digest_valid_o` are both 1 and `digest_o` holds the initial hash value. This holds even when the pulse arrives mid-block or during the busy window, and any partly loaded block is discarded.
- R3: A word is accepted on a rising edge where `wr_valid_i` and `ready_o` are both 1 and `start_i` is 0. `ready_o` stays 1 while the first fifteen words of a block are accepted.
- R4: In the cycle after the first word of a block is accepted, `digest_valid_o` is 0.
- R5: After the sixteenth word of a block is accepted, `ready_o` is 0 for exactly 57 consecutive cycles and then returns to 1.
- R6: `digest_valid_o` is 0 whenever `ready_o` is 0. Both return to 1 together at the end of the busy window.
- R7: At the end of the busy window, `digest_o` equals the FIPS 180-4 SHA-256 compression of the block into the previous digest. The first word accepted is the most significant word of the block, and the output word order is H0 down to H7 from the top bits.
- R8: Blocks chain: without a new start, the next block compresses into the digest left by the previous block.
- R9: A word presented while `ready_o` is 0 is ignored and does not change the digest or the word count.
- R10: When `start_i` and `wr_valid_i` are both 1 on the same edge, the start takes effect and the word is discarded, so `digest_valid_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | One-cycle pulse: reload the initial hash and clear the word count |
| wr_valid_i | input | 1 | A message word is presented |
| wr_data_i | input | 32 | Message word |
| ready_o | output | 1 | Engine can accept a word |
| digest_valid_o | output | 1 | Digest on `digest_o` is complete |
| digest_o | output | 256 | Running digest, H0 in bits 255:224 through H7 in bits 31:0 |

## Verification
On every cycle, the assertions check the following:
- `digest_valid_o` drops after the first word of a block.
- `ready_o` stays high through the first fifteen words and stays low for the whole busy window.
- A start forces both flags high.
- `digest_valid_o` is never high while `ready_o` is low.
- The digest moves only on a start or on the final add.

Only the bench's scenarios can show the rest:
- the digest values, which are checked against published SHA-256 results for single-block and two-block messages;
- the exact 57-cycle window length;
- that words offered during the busy window leave no trace;
- that a start mid-block, during the busy window, or together with a write discards the old state.

// File: rtl/sha256_pkg.sv
package sha256_pkg;

  typedef logic [7:0][31:0] sha_state_t;

  // index 0 holds a / H0
  localparam sha_state_t SHA_IV = {
    32'h5be0cd19, 32'h1f83d9ab, 32'h9b05688c, 32'h510e527f,
    32'ha54ff53a, 32'h3c6ef372, 32'hbb67ae85, 32'h6a09e667
  };

  function automatic logic [31:0] rotr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [31:0] big_sig0(input logic [31:0] x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic logic [31:0] big_sig1(input logic [31:0] x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic logic [31:0] small_sig0(input logic [31:0] x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic logic [31:0] small_sig1(input logic [31:0] x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

  function automatic logic [31:0] round_const(input logic [5:0] idx);
    case (idx)
      6'd0:  return 32'h428a2f98;  6'd1:  return 32'h71374491;
      6'd2:  return 32'hb5c0fbcf;  6'd3:  return 32'he9b5dba5;
      6'd4:  return 32'h3956c25b;  6'd5:  return 32'h59f111f1;
      6'd6:  return 32'h923f82a4;  6'd7:  return 32'hab1c5ed5;
      6'd8:  return 32'hd807aa98;  6'd9:  return 32'h12835b01;
      6'd10: return 32'h243185be;  6'd11: return 32'h550c7dc3;
      6'd12: return 32'h72be5d74;  6'd13: return 32'h80deb1fe;
      6'd14: return 32'h9bdc06a7;  6'd15: return 32'hc19bf174;
      6'd16: return 32'he49b69c1;  6'd17: return 32'hefbe4786;
      6'd18: return 32'h0fc19dc6;  6'd19: return 32'h240ca1cc;
      6'd20: return 32'h2de92c6f;  6'd21: return 32'h4a7484aa;
      6'd22: return 32'h5cb0a9dc;  6'd23: return 32'h76f988da;
      6'd24: return 32'h983e5152;  6'd25: return 32'ha831c66d;
      6'd26: return 32'hb00327c8;  6'd27: return 32'hbf597fc7;
      6'd28: return 32'hc6e00bf3;  6'd29: return 32'hd5a79147;
      6'd30: return 32'h06ca6351;  6'd31: return 32'h14292967;
      6'd32: return 32'h27b70a85;  6'd33: return 32'h2e1b2138;
      6'd34: return 32'h4d2c6dfc;  6'd35: return 32'h53380d13;
      6'd36: return 32'h650a7354;  6'd37: return 32'h766a0abb;
      6'd38: return 32'h81c2c92e;  6'd39: return 32'h92722c85;
      6'd40: return 32'ha2bfe8a1;  6'd41: return 32'ha81a664b;
      6'd42: return 32'hc24b8b70;  6'd43: return 32'hc76c51a3;
      6'd44: return 32'hd192e819;  6'd45: return 32'hd6990624;
      6'd46: return 32'hf40e3585;  6'd47: return 32'h106aa070;
      6'd48: return 32'h19a4c116;  6'd49: return 32'h1e376c08;
      6'd50: return 32'h2748774c;  6'd51: return 32'h34b0bcb5;
      6'd52: return 32'h391c0cb3;  6'd53: return 32'h4ed8aa4a;
      6'd54: return 32'h5b9cca4f;  6'd55: return 32'h682e6ff3;
      6'd56: return 32'h748f82ee;  6'd57: return 32'h78a5636f;
      6'd58: return 32'h84c87814;  6'd59: return 32'h8cc70208;
      6'd60: return 32'h90befffa;  6'd61: return 32'ha4506ceb;
      6'd62: return 32'hbef9a3f7;  default: return 32'hc67178f2;
    endcase
  endfunction

  function automatic sha_state_t sha_round(input sha_state_t s,
                                           input logic [31:0] k,
                                           input logic [31:0] w);
    logic [31:0] t1, t2, ch, mj;
    sha_state_t r;
    ch = (s[4] & s[5]) ^ (~s[4] & s[6]);
    mj = (s[0] & s[1]) ^ (s[0] & s[2]) ^ (s[1] & s[2]);
    t1 = s[7] + big_sig1(s[4]) + ch + k + w;
    t2 = big_sig0(s[0]) + mj;
    r[0] = t1 + t2;
    r[1] = s[0];
    r[2] = s[1];
    r[3] = s[2];
    r[4] = s[3] + t1;
    r[5] = s[4];
    r[6] = s[5];
    r[7] = s[6];
    return r;
  endfunction

endpackage

// File: rtl/sha256_ctrl.sv
module sha256_ctrl #(
  parameter int BUSY_CYCLES = 57,
  parameter int BLOCK_WORDS = 16,
  parameter int TOTAL_ROUNDS = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       wr_valid_i,
  output logic       ready_o,
  output logic       valid_o,
  output logic       round_en_o,
  output logic       first_o,
  output logic       expand_o,
  output logic       add_en_o,
  output logic [5:0] round_idx_o
);
  localparam int WCW = $clog2(BLOCK_WORDS);
  localparam int BCW = $clog2(BUSY_CYCLES);
  localparam int TAIL_ROUNDS = TOTAL_ROUNDS - BLOCK_WORDS;
  localparam logic [WCW-1:0] LAST_WORD = WCW'(BLOCK_WORDS - 1);
  localparam logic [BCW-1:0] LAST_BUSY = BCW'(BUSY_CYCLES - 1);
  localparam logic [BCW-1:0] ADD_SLOT  = BCW'(TAIL_ROUNDS);

  typedef enum logic {ST_LOAD, ST_BUSY} st_t;

  st_t            st_q, st_d;
  logic [WCW-1:0] wcnt_q, wcnt_d;
  logic [BCW-1:0] bcnt_q, bcnt_d;
  logic           valid_q, valid_d;
  logic           accept;

  assign ready_o = (st_q == ST_LOAD);
  assign valid_o = valid_q;
  assign accept  = wr_valid_i & ready_o & ~start_i;

  assign round_en_o  = accept | (st_q == ST_BUSY && bcnt_q < ADD_SLOT && !start_i);
  assign first_o     = accept && wcnt_q == '0;
  assign expand_o    = (st_q == ST_BUSY);
  assign add_en_o    = (st_q == ST_BUSY) && bcnt_q == ADD_SLOT && !start_i;
  assign round_idx_o = accept ? 6'(wcnt_q) : 6'(bcnt_q + BCW'(BLOCK_WORDS));

  always_comb begin
    st_d    = st_q;
    wcnt_d  = wcnt_q;
    bcnt_d  = bcnt_q;
    valid_d = valid_q;
    if (start_i) begin
      st_d    = ST_LOAD;
      wcnt_d  = '0;
      bcnt_d  = '0;
      valid_d = 1'b1;
    end else if (accept) begin
      wcnt_d = wcnt_q + 1'b1;
      if (wcnt_q == '0) valid_d = 1'b0;
      if (wcnt_q == LAST_WORD) begin
        st_d   = ST_BUSY;
        bcnt_d = '0;
      end
    end else if (st_q == ST_BUSY) begin
      bcnt_d = bcnt_q + 1'b1;
      if (bcnt_q == LAST_BUSY) begin
        st_d    = ST_LOAD;
        valid_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_LOAD;
      wcnt_q  <= '0;
      bcnt_q  <= '0;
      valid_q <= 1'b1;
    end else begin
      st_q    <= st_d;
      wcnt_q  <= wcnt_d;
      bcnt_q  <= bcnt_d;
      valid_q <= valid_d;
    end
  end

  assert_start_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (ready_o && valid_o));

  assert_ready_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && wcnt_q != LAST_WORD) |=> ready_o);

  assert_valid_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && wcnt_q == '0) |=> !valid_o);

  assert_busy_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BUSY && bcnt_q != LAST_BUSY && !start_i) |=> !ready_o);

  assert_valid_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o |-> !valid_o);

endmodule

// File: rtl/sha256_sched.sv
module sha256_sched #(
  parameter int WORD_W = 32,
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_i,
  input  logic              expand_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] w_o
);
  import sha256_pkg::*;

  // win_q[0] is the oldest word (t-16), win_q[DEPTH-1] the newest (t-1)
  logic [WORD_W-1:0] win_q [DEPTH];
  logic [WORD_W-1:0] win_d [DEPTH];
  logic [WORD_W-1:0] expanded;

  assign expanded = small_sig1(win_q[DEPTH-2]) + win_q[DEPTH-7]
                  + small_sig0(win_q[1]) + win_q[0];
  assign w_o = expand_i ? expanded : data_i;

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_win
      if (gi == DEPTH - 1) begin : g_tail
        assign win_d[gi] = shift_i ? w_o : win_q[gi];
      end else begin : g_body
        assign win_d[gi] = shift_i ? win_q[gi+1] : win_q[gi];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q[gi] <= '0;
        else        win_q[gi] <= win_d[gi];
      end
    end
  endgenerate

endmodule

// File: rtl/sha256_datapath.sv
module sha256_datapath (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  init_i,
  input  logic                  round_en_i,
  input  logic                  first_i,
  input  logic                  add_en_i,
  input  logic [5:0]            round_idx_i,
  input  logic [31:0]           w_i,
  output sha256_pkg::sha_state_t dig_o
);
  import sha256_pkg::*;

  sha_state_t dig_q, dig_d;
  sha_state_t work_q, work_d;
  sha_state_t src;

  assign src   = first_i ? dig_q : work_q;
  assign dig_o = dig_q;

  always_comb begin
    dig_d  = dig_q;
    work_d = work_q;
    if (init_i) begin
      dig_d = SHA_IV;
    end else begin
      if (round_en_i) work_d = sha_round(src, round_const(round_idx_i), w_i);
      if (add_en_i) begin
        for (int i = 0; i < 8; i++) dig_d[i] = dig_q[i] + work_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dig_q  <= SHA_IV;
      work_q <= '0;
    end else begin
      dig_q  <= dig_d;
      work_q <= work_d;
    end
  end

  // R9: the digest moves only on a start or on the final add
  assert_digest_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && !add_en_i) |=> $stable(dig_q));

endmodule

// File: rtl/sha256_block_engine.sv
module sha256_block_engine #(
  parameter int BUSY_CYCLES = 57
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         wr_valid_i,
  input  logic [31:0]  wr_data_i,
  output logic         ready_o,
  output logic         digest_valid_o,
  output logic [255:0] digest_o
);
  import sha256_pkg::*;

  localparam int BLOCK_WORDS = 16;
  localparam int TOTAL_ROUNDS = 64;

  logic        round_en, first, expand, add_en;
  logic [5:0]  round_idx;
  logic [31:0] w_t;
  sha_state_t  dig;

  sha256_ctrl #(
    .BUSY_CYCLES (BUSY_CYCLES),
    .BLOCK_WORDS (BLOCK_WORDS),
    .TOTAL_ROUNDS(TOTAL_ROUNDS)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .wr_valid_i (wr_valid_i),
    .ready_o    (ready_o),
    .valid_o    (digest_valid_o),
    .round_en_o (round_en),
    .first_o    (first),
    .expand_o   (expand),
    .add_en_o   (add_en),
    .round_idx_o(round_idx)
  );

  sha256_sched #(.WORD_W(32), .DEPTH(BLOCK_WORDS)) u_sched (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_i (round_en),
    .expand_i(expand),
    .data_i  (wr_data_i),
    .w_o     (w_t)
  );

  sha256_datapath u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_i     (start_i),
    .round_en_i (round_en),
    .first_i    (first),
    .add_en_i   (add_en),
    .round_idx_i(round_idx),
    .w_i        (w_t),
    .dig_o      (dig)
  );

  genvar gi;
  generate
    for (gi = 0; gi < 8; gi++) begin : g_out
      assign digest_o[255-32*gi -: 32] = dig[gi];
    end
  endgenerate

endmodule

// File: tb/tb_sha256_block_engine.sv
module tb_sha256_block_engine;

  logic         clk;
  logic         rst_n;
  logic         start_i;
  logic         wr_valid_i;
  logic [31:0]  wr_data_i;
  logic         ready_o;
  logic         digest_valid_o;
  logic [255:0] digest_o;

  int n_checks;
  int n_fail;

  localparam logic [255:0] IV_EXP =
    256'h6a09e667bb67ae853c6ef372a54ff53a510e527f9b05688c1f83d9ab5be0cd19;
  localparam logic [255:0] EMPTY_EXP =
    256'he3b0c44298fc1c149afbf4c8996fb92427ae41e4649b934ca495991b7852b855;
  localparam logic [255:0] ABC_EXP =
    256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad;
  localparam logic [511:0] EMPTY_BLK = {32'h80000000, 480'h0};
  localparam logic [511:0] ABC_BLK = {32'h61626380, 448'h0, 32'h00000018};

  localparam int NV = 4;
  localparam logic [511:0] VEC_BLK [NV] = '{
    EMPTY_BLK,
    ABC_BLK,
    {32'h61626364, 32'h62636465, 32'h63646566, 32'h64656667,
     32'h65666768, 32'h66676869, 32'h6768696a, 32'h68696a6b,
     32'h696a6b6c, 32'h6a6b6c6d, 32'h6b6c6d6e, 32'h6c6d6e6f,
     32'h6d6e6f70, 32'h6e6f7071, 32'h80000000, 32'h00000000},
    {480'h0, 32'h000001c0}
  };
  localparam logic [255:0] VEC_EXP [NV] = '{
    EMPTY_EXP, ABC_EXP, 256'h0,
    256'h248d6a61d20638b8e5c026930c3e6039a33ce45964ff2167f6ecedd419db06c1
  };
  localparam bit VEC_START [NV] = '{1'b1, 1'b1, 1'b1, 1'b0};
  localparam bit VEC_CHECK [NV] = '{1'b1, 1'b1, 1'b0, 1'b1};

  sha256_block_engine dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .wr_valid_i    (wr_valid_i),
    .wr_data_i     (wr_data_i),
    .ready_o       (ready_o),
    .digest_valid_o(digest_valid_o),
    .digest_o      (digest_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic put_word(input logic [31:0] d);
    @(negedge clk);
    wr_valid_i = 1'b1;
    wr_data_i  = d;
    @(negedge clk);
    wr_valid_i = 1'b0;
  endtask

  // sends a block, checks R3/R4/R5/R6, offers junk words during the busy window (R9)
  task automatic send_block(input logic [511:0] blk);
    int busy;
    logic hold_ok;
    hold_ok = 1'b1;
    for (int j = 0; j < 16; j++) begin
      put_word(blk[511-32*j -: 32]);
      if (j == 0) check("R4 valid after first word", {255'h0, digest_valid_o}, 256'h0);
      if (j < 15 && ready_o !== 1'b1) hold_ok = 1'b0;
    end
    check("R3 ready through first fifteen words", {255'h0, hold_ok}, 256'h1);
    busy = 0;
    wr_valid_i = 1'b1;
    wr_data_i  = 32'hdeadbeef;
    while (ready_o === 1'b0 && busy < 200) begin
      busy++;
      @(negedge clk);
    end
    wr_valid_i = 1'b0;
    check("R5 busy window length", 256'(busy), 256'd57);
    check("R6 valid back with ready", {255'h0, digest_valid_o}, 256'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    n_checks   = 0;
    n_fail     = 0;
    rst_n      = 1'b0;
    start_i    = 1'b0;
    wr_valid_i = 1'b0;
    wr_data_i  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 ready", {255'h0, ready_o}, 256'h1);
    check("R1 valid", {255'h0, digest_valid_o}, 256'h1);
    check("R1 digest", digest_o, IV_EXP);

    // vector table: R7 single blocks, R8 chained two-block message
    for (int v = 0; v < NV; v++) begin
      if (VEC_START[v]) begin
        pulse_start();
        check("R2 start flags", {254'h0, ready_o, digest_valid_o}, 256'h3);
      end
      send_block(VEC_BLK[v]);
      if (VEC_CHECK[v]) check(v == 3 ? "R8 chained digest" : "R7 digest", digest_o, VEC_EXP[v]);
    end

    // R2: start mid-block discards the partial block
    pulse_start();
    for (int j = 0; j < 5; j++) put_word(32'h13572468 + j);
    pulse_start();
    check("R2 mid-block flags", {254'h0, ready_o, digest_valid_o}, 256'h3);
    check("R2 mid-block digest", digest_o, IV_EXP);
    send_block(ABC_BLK);
    check("R2 digest after restart", digest_o, ABC_EXP);

    // R2: start during the busy window aborts it
    pulse_start();
    for (int j = 0; j < 16; j++) put_word(32'h0badf00d);
    repeat (10) @(negedge clk);
    check("R2 busy before start", {255'h0, ready_o}, 256'h0);
    pulse_start();
    check("R2 busy abort flags", {254'h0, ready_o, digest_valid_o}, 256'h3);
    check("R2 busy abort digest", digest_o, IV_EXP);
    send_block(EMPTY_BLK);
    check("R2 digest after abort", digest_o, EMPTY_EXP);

    // R10: start and write on the same edge
    @(negedge clk);
    start_i    = 1'b1;
    wr_valid_i = 1'b1;
    wr_data_i  = 32'hffffffff;
    @(negedge clk);
    start_i    = 1'b0;
    wr_valid_i = 1'b0;
    check("R10 valid kept", {255'h0, digest_valid_o}, 256'h1);
    check("R10 digest", digest_o, IV_EXP);
    send_block(ABC_BLK);
    check("R10 word discarded", digest_o, ABC_EXP);

    report();
  end

endmodule